// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits next to a processor core and decides which pending interrupt the core should take next. Requests arrive one per cycle, each carrying an 8-bit vector, a 3-bit delivery mode and a level/edge trigger flag. Ordinary vectored requests are held in a 256-entry request bitmap. Vectors the core has accepted but not yet finished move into a 256-entry in-service bitmap. The trigger kind of every queued vector is kept in a third bitmap. A separate set of one-deep pending flags holds the special delivery kinds. These are the system-management, non-maskable, init, startup and external kinds, and none of them uses a bitmap.

Each cycle the block presents a single candidate: its kind, its vector and, for ordinary vectors, its trigger kind. The core takes the candidate by pulsing acknowledge while the candidate is valid. An ordinary vector then moves from the request bitmap to the in-service bitmap, and a special kind clears its flag. A one-cycle end-of-service strobe retires the highest in-service vector. A task-priority register sets a class threshold, and an ordinary vector must exceed that threshold to be offered.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset all bitmaps, special flags and the task-priority register are clear, so `irq_valid` and `irq_nmi_class` are 0.
- R2: A request with mode 0 (fixed) or 1 (lowest-priority) sets the bitmap bit of its vector and records its trigger kind. When that vector is later offered, `irq_kind` is 0 and `irq_level` shows the recorded trigger kind (1 = level).
- R3: A mode 0/1 request for a vector whose request bit is already set has no effect, and the recorded trigger kind is not changed.
- R4: Mode 3 is reserved, and a request carrying it has no effect.
- R5: Modes 2 (system-management), 4 (non-maskable), 5 (init), 6 (startup) and 7 (external) each set their own pending flag. A repeat request while that flag is set is dropped. Startup and external latch their vector with the flag, and a dropped repeat leaves that vector unchanged. The other special kinds are offered with vector 0.
- R6: Offer priority is mode 2, then 4, then 5, then 6, then 7, then ordinary vectors, and `irq_kind` carries the offered mode number.
- R7: `irq_nmi_class` is 1 exactly while any of the mode 2, 4, 5 or 6 flags is pending.
- R8: Among ordinary vectors only the highest pending index is offered, and only when that index is greater than the highest in-service index (an empty bitmap counts as index 0).
- R9: An ordinary vector is offered only when its bits 7:4 are greater than bits 7:4 of the task-priority register, which is loaded by `tpr_wr`.
- R10: An acknowledge while `irq_valid` is 1 moves an offered ordinary vector from the request bitmap to the in-service bitmap, or clears the flag of an offered special kind.
- R11: An acknowledge while `irq_valid` is 0 has no effect.
- R12: An `eoi_wr` strobe clears the highest set in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request strobe |
| req_vector | input | 8 | Vector of the request |
| req_mode | input | 3 | Delivery mode of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Load the task-priority register |
| tpr_value | input | 8 | New task-priority value |
| eoi_wr | input | 1 | End-of-service strobe |
| irq_ack | input | 1 | Core takes the offered interrupt |
| irq_valid | output | 1 | An interrupt is offered |
| irq_kind | output | 3 | Mode number of the offered interrupt |
| irq_vector | output | 8 | Vector of the offered interrupt |
| irq_level | output | 1 | Trigger kind of an offered ordinary vector |
| irq_nmi_class | output | 1 | A non-maskable-class flag is pending |

## Verification
The bench loads several ordinary vectors out of index order. The offer sequence shows whether the highest index wins and whether a lower vector is correctly held back behind an in-service one until the end-of-service strobe. A mix of all five special kinds, sent together with an ordinary vector and with repeated startup and external requests, separates the fixed priority chain from the bitmap path and tests the drop-on-repeat behaviour. Task-priority settings at, below and above a vector's class check the strict class comparison. An acknowledge given with no offer shows that a stray acknowledge leaves the queued state untouched.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int VEC_W = 8;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      DM_FIXED  = 3'd0,
      DM_LOWEST = 3'd1,
      DM_SMI    = 3'd2,
      DM_RSVD   = 3'd3,
      DM_NMI    = 3'd4,
      DM_INIT   = 3'd5,
      DM_START  = 3'd6,
      DM_EXT    = 3'd7
   } dmode_e;
endpackage

// File: rtl/irq_msb_enc.sv
module irq_msb_enc #(
   parameter int N     = 256,
   parameter int GROUP = 16
) (
   input  logic [N-1:0]         bits_i,
   output logic                 any_o,
   output logic [$clog2(N)-1:0] idx_o
);
   localparam int IW = $clog2(N);

   if (GROUP < 2 || (N % GROUP) != 0) begin : g_bad_group
      $error("irq_msb_enc: GROUP must be at least 2 and divide N");
   end

   if (GROUP >= N) begin : g_flat
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < N; i++)
            if (bits_i[i]) idx_o = IW'(i);
      end
      assign any_o = |bits_i;
   end else begin : g_tree
      localparam int NG = N / GROUP;
      localparam int GW = $clog2(GROUP);
      logic [NG-1:0]    grp_any;
      logic [NG*GW-1:0] grp_idx;

      for (genvar g = 0; g < NG; g++) begin : g_grp
         logic [GW-1:0] loc;
         always_comb begin
            loc = '0;
            for (int j = 0; j < GROUP; j++)
               if (bits_i[g*GROUP + j]) loc = GW'(j);
         end
         assign grp_idx[g*GW +: GW] = loc;
         assign grp_any[g] = |bits_i[g*GROUP +: GROUP];
      end

      always_comb begin
         idx_o = '0;
         for (int g = 0; g < NG; g++)
            if (grp_any[g]) idx_o = IW'(g*GROUP) + IW'(grp_idx[g*GW +: GW]);
      end
      assign any_o = |grp_any;
   end
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
   parameter int N = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [$clog2(N)-1:0] set_idx,
   input  logic                 clr_en,
   input  logic [$clog2(N)-1:0] clr_idx,
   output logic [N-1:0]         bits_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_o <= '0;
      end else begin
         if (clr_en) bits_o[clr_idx] <= 1'b0;
         if (set_en) bits_o[set_idx] <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_special_flags.sv
module irq_special_flags
   import irq_arb_pkg::*;
#(
   parameter int VW = VEC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  dmode_e        req_mode,
   input  logic [VW-1:0] req_vector,
   input  logic          take_en,
   input  dmode_e        take_kind,
   output logic          smi_o,
   output logic          nmi_o,
   output logic          init_o,
   output logic          start_o,
   output logic          ext_o,
   output logic [VW-1:0] start_vec_o,
   output logic [VW-1:0] ext_vec_o
);
   function automatic logic hit(input logic v, input dmode_e m, input dmode_e k);
      return v && (m == k);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smi_o       <= 1'b0;
         nmi_o       <= 1'b0;
         init_o      <= 1'b0;
         start_o     <= 1'b0;
         ext_o       <= 1'b0;
         start_vec_o <= '0;
         ext_vec_o   <= '0;
      end else begin
         if (hit(take_en, take_kind, DM_SMI))   smi_o   <= 1'b0;
         if (hit(take_en, take_kind, DM_NMI))   nmi_o   <= 1'b0;
         if (hit(take_en, take_kind, DM_INIT))  init_o  <= 1'b0;
         if (hit(take_en, take_kind, DM_START)) start_o <= 1'b0;
         if (hit(take_en, take_kind, DM_EXT))   ext_o   <= 1'b0;
         if (hit(req_valid, req_mode, DM_SMI)  && !smi_o)  smi_o  <= 1'b1;
         if (hit(req_valid, req_mode, DM_NMI)  && !nmi_o)  nmi_o  <= 1'b1;
         if (hit(req_valid, req_mode, DM_INIT) && !init_o) init_o <= 1'b1;
         if (hit(req_valid, req_mode, DM_START) && !start_o) begin
            start_o     <= 1'b1;
            start_vec_o <= req_vector;
         end
         if (hit(req_valid, req_mode, DM_EXT) && !ext_o) begin
            ext_o     <= 1'b1;
            ext_vec_o <= req_vector;
         end
      end
   end

   // R5: a repeat while pending keeps the latched vector
   p_ext_repeat_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_o && req_valid && req_mode == DM_EXT |=> ext_vec_o == $past(ext_vec_o));
   p_start_repeat_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_o && req_valid && req_mode == DM_START |=> start_vec_o == $past(start_vec_o));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int VW      = VEC_W,
   parameter int CLASS_W = 4,
   parameter int GROUP   = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [7:0]    req_vector,
   input  logic [2:0]    req_mode,
   input  logic          req_level,
   input  logic          tpr_wr,
   input  logic [7:0]    tpr_value,
   input  logic          eoi_wr,
   input  logic          irq_ack,
   output logic          irq_valid,
   output logic [2:0]    irq_kind,
   output logic [7:0]    irq_vector,
   output logic          irq_level,
   output logic          irq_nmi_class
);
   localparam int NV = 1 << VW;

   if (VW != 8) begin : g_bad_vw
      $error("irq_prio_arbiter: port vectors are 8 bits wide");
   end
   if (CLASS_W < 1 || CLASS_W > VW) begin : g_bad_class
      $error("irq_prio_arbiter: CLASS_W out of range");
   end

   dmode_e        mode;
   dmode_e        kind;
   logic [NV-1:0] irr_bits, isr_bits, tmr_bits;
   logic          irr_any, isr_any;
   logic [VW-1:0] irr_top, isr_top;
   logic [VW-1:0] tpr_q;
   logic          smi_p, nmi_p, init_p, start_p, ext_p;
   logic [VW-1:0] start_vec, ext_vec;
   logic          queue_req, irr_set, take, take_reg, reg_ok;

   assign mode      = dmode_e'(req_mode);
   assign queue_req = req_valid && (mode == DM_FIXED || mode == DM_LOWEST);
   assign irr_set   = queue_req && !irr_bits[req_vector];
   assign take      = irq_ack && irq_valid;
   assign take_reg  = take && kind == DM_FIXED;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tpr_q <= '0;
      else if (tpr_wr) tpr_q <= tpr_value;
   end

   irq_vec_map #(.N(NV)) u_irr (
      .clk(clk), .rst_n(rst_n),
      .set_en(irr_set), .set_idx(req_vector),
      .clr_en(take_reg), .clr_idx(irr_top),
      .bits_o(irr_bits));

   irq_vec_map #(.N(NV)) u_isr (
      .clk(clk), .rst_n(rst_n),
      .set_en(take_reg), .set_idx(irr_top),
      .clr_en(eoi_wr && isr_any), .clr_idx(isr_top),
      .bits_o(isr_bits));

   irq_vec_map #(.N(NV)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .set_en(irr_set && req_level), .set_idx(req_vector),
      .clr_en(irr_set && !req_level), .clr_idx(req_vector),
      .bits_o(tmr_bits));

   irq_msb_enc #(.N(NV), .GROUP(GROUP)) u_irr_enc (
      .bits_i(irr_bits), .any_o(irr_any), .idx_o(irr_top));

   irq_msb_enc #(.N(NV), .GROUP(GROUP)) u_isr_enc (
      .bits_i(isr_bits), .any_o(isr_any), .idx_o(isr_top));

   irq_special_flags #(.VW(VW)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_mode(mode), .req_vector(req_vector),
      .take_en(take), .take_kind(kind),
      .smi_o(smi_p), .nmi_o(nmi_p), .init_o(init_p), .start_o(start_p),
      .ext_o(ext_p), .start_vec_o(start_vec), .ext_vec_o(ext_vec));

   assign reg_ok = irr_any && (irr_top > isr_top) &&
                   (irr_top[VW-1 -: CLASS_W] > tpr_q[VW-1 -: CLASS_W]);

   always_comb begin
      irq_valid  = 1'b1;
      kind       = DM_FIXED;
      irq_vector = '0;
      irq_level  = 1'b0;
      if (smi_p)        kind = DM_SMI;
      else if (nmi_p)   kind = DM_NMI;
      else if (init_p)  kind = DM_INIT;
      else if (start_p) begin
         kind       = DM_START;
         irq_vector = start_vec;
      end else if (ext_p) begin
         kind       = DM_EXT;
         irq_vector = ext_vec;
      end else if (reg_ok) begin
         irq_vector = irr_top;
         irq_level  = tmr_bits[irr_top];
      end else begin
         irq_valid  = 1'b0;
      end
   end

   assign irq_kind      = kind;
   assign irq_nmi_class = smi_p | nmi_p | init_p | start_p;

   // R7: non-maskable class pending means a special kind is offered
   p_nmi_class_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_nmi_class |-> irq_valid && (irq_kind inside {3'd2, 3'd4, 3'd5, 3'd6}));
   // R8: offered ordinary vector is above every in-service vector
   p_above_service_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && irq_kind == 3'd0 |-> irq_vector > isr_top);
   // R10: acknowledged ordinary vector lands in service and leaves the queue
   p_ack_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && irq_valid && irq_kind == 3'd0 |=>
         isr_bits[$past(irq_vector)] && !irr_bits[$past(irq_vector)]);
   // R11: stray acknowledge leaves the bitmaps alone
   p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !irq_valid && !req_valid && !eoi_wr |=>
         $stable(irr_bits) && $stable(isr_bits) && $stable(irq_nmi_class));
   // R12: end-of-service retires the top in-service vector
   p_eoi_retire_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_wr && isr_any |=> !isr_bits[$past(isr_top)]);
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
module irq_prio_arbiter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [7:0] req_vector = '0;
   logic [2:0] req_mode = '0;
   logic       req_level = 1'b0;
   logic       tpr_wr = 1'b0;
   logic [7:0] tpr_value = '0;
   logic       eoi_wr = 1'b0;
   logic       mon_ack = 1'b0;
   logic       man_ack = 1'b0;
   logic       irq_ack;
   logic       irq_valid;
   logic [2:0] irq_kind;
   logic [7:0] irq_vector;
   logic       irq_level;
   logic       irq_nmi_class;

   int checks = 0;
   int errors = 0;
   bit auto_ack = 1'b0;
   bit done = 1'b0;
   logic [11:0] exp_q[$];
   string       tag_q[$];

   assign irq_ack = mon_ack | man_ack;

   always #10 clk = ~clk;

   irq_prio_arbiter dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vector(req_vector), .req_mode(req_mode),
      .req_level(req_level), .tpr_wr(tpr_wr), .tpr_value(tpr_value),
      .eoi_wr(eoi_wr), .irq_ack(irq_ack), .irq_valid(irq_valid),
      .irq_kind(irq_kind), .irq_vector(irq_vector), .irq_level(irq_level),
      .irq_nmi_class(irq_nmi_class));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [2:0] k, input logic l, input logic [7:0] v,
                       input string tag);
      exp_q.push_back({k, l, v});
      tag_q.push_back(tag);
   endtask

   // monitor: compare offer to queue head, then acknowledge it
   always @(negedge clk) begin
      if (auto_ack && exp_q.size() > 0) begin
         logic [11:0] item;
         string t;
         item = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(irq_valid && {irq_kind, irq_level, irq_vector} == item, t,
             {19'd0, irq_valid, irq_kind, irq_level, irq_vector}, {20'h1, item});
         mon_ack = 1'b1;
      end else begin
         mon_ack = 1'b0;
      end
   end

   task automatic send(input logic [2:0] m, input logic [7:0] v, input logic l);
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; req_vector = v; req_level = l;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic set_tpr(input logic [7:0] v);
      @(negedge clk);
      tpr_wr = 1'b1; tpr_value = v;
      @(negedge clk);
      tpr_wr = 1'b0;
   endtask

   task automatic eoi();
      @(negedge clk);
      eoi_wr = 1'b1;
      @(negedge clk);
      eoi_wr = 1'b0;
   endtask

   task automatic drain();
      auto_ack = 1'b1;
      wait (exp_q.size() == 0);
      @(negedge clk);
      auto_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!irq_valid && !irq_nmi_class, "R1 reset idle", {irq_valid, irq_nmi_class}, 0);

      // R9 threshold blocks, R11 stray ack ignored
      set_tpr(8'hF0);
      send(3'd0, 8'h40, 1'b0);
      chk(!irq_valid, "R9 class below tpr held", irq_valid, 0);
      @(negedge clk); man_ack = 1'b1;
      @(negedge clk); man_ack = 1'b0;
      set_tpr(8'h00);
      chk(irq_valid && irq_vector == 8'h40, "R11 stray ack kept vector",
          irq_vector, 8'h40);
      push(3'd0, 1'b0, 8'h40, "R2 fixed edge vector");
      drain();
      eoi();

      // R4 reserved mode
      send(3'd3, 8'h99, 1'b1);
      chk(!irq_valid, "R4 reserved mode ignored", irq_valid, 0);

      // R8 / R3 / R2 ordering and in-service blocking
      send(3'd0, 8'h31, 1'b1);
      send(3'd0, 8'h85, 1'b0);
      send(3'd1, 8'h62, 1'b1);
      send(3'd0, 8'h31, 1'b0);
      push(3'd0, 1'b0, 8'h85, "R8 highest pending first");
      drain();
      chk(!irq_valid, "R8 lower vector held behind service", irq_valid, 0);
      eoi();
      push(3'd0, 1'b1, 8'h62, "R2 lowest-priority mode level");
      drain();
      eoi();
      push(3'd0, 1'b1, 8'h31, "R3 repeat kept level trigger");
      drain();
      eoi();
      chk(!irq_valid, "R10 queue emptied by acks", irq_valid, 0);

      // R12 nested service
      send(3'd0, 8'h20, 1'b0);
      push(3'd0, 1'b0, 8'h20, "R12 first nested");
      drain();
      send(3'd0, 8'h90, 1'b0);
      push(3'd0, 1'b0, 8'h90, "R12 second nested");
      drain();
      send(3'd0, 8'h50, 1'b0);
      chk(!irq_valid, "R8 0x50 below 0x90 in service", irq_valid, 0);
      eoi();
      chk(irq_valid && irq_vector == 8'h50, "R12 eoi retired top only",
          irq_vector, 8'h50);
      push(3'd0, 1'b0, 8'h50, "R12 released vector");
      drain();
      eoi();
      eoi();
      chk(!irq_valid, "R12 all retired", irq_valid, 0);

      // R9 strict class compare
      set_tpr(8'h5F);
      send(3'd0, 8'h55, 1'b0);
      chk(!irq_valid, "R9 equal class held", irq_valid, 0);
      send(3'd0, 8'h61, 1'b1);
      push(3'd0, 1'b1, 8'h61, "R9 higher class offered");
      drain();
      eoi();
      set_tpr(8'h00);
      push(3'd0, 1'b0, 8'h55, "R9 released after tpr drop");
      drain();
      eoi();

      // R5 R6 R7 special kinds
      send(3'd7, 8'h33, 1'b0);
      send(3'd6, 8'h12, 1'b0);
      send(3'd5, 8'h00, 1'b0);
      send(3'd4, 8'h00, 1'b0);
      send(3'd2, 8'h00, 1'b0);
      send(3'd0, 8'hA0, 1'b0);
      send(3'd7, 8'h44, 1'b0);
      send(3'd6, 8'h77, 1'b0);
      chk(irq_nmi_class, "R7 class flag while pending", irq_nmi_class, 1);
      push(3'd2, 1'b0, 8'h00, "R6 smi first");
      push(3'd4, 1'b0, 8'h00, "R6 nmi second");
      push(3'd5, 1'b0, 8'h00, "R6 init third");
      push(3'd6, 1'b0, 8'h12, "R5 startup vector kept");
      drain();
      chk(!irq_nmi_class && irq_kind == 3'd7, "R7 class clear, external next",
          {irq_nmi_class, irq_kind}, 4'h7);
      push(3'd7, 1'b0, 8'h33, "R5 external vector kept");
      push(3'd0, 1'b0, 8'hA0, "R6 ordinary vector last");
      drain();
      eoi();
      chk(!irq_valid, "R10 specials cleared by ack", irq_valid, 0);

      done = 1'b1;
      finish_run();
   end
endmodule